// File: doc/BRIEF.md
# Parallel Display Command Bridge

This block sits between a 32-bit register bus and up to two external display-controller chips on a 16-bit parallel bus. Software writes command words, parameter words and pixel words into fixed register offsets. The block turns each one into strobed cycles on the chips that the control register selects. A data/command line (A0) tells each chip whether the word is a command (A0=0) or a parameter or pixel (A0=1). A 32-bit pixel write becomes two 16-bit cycles. While the second cycle is still pending, the block holds the bus off through a ready output.

Read-back works the same way. A write to one of two read-trigger offsets runs one read cycle on a single selected chip, and the returned word is latched into a 16-bit receive buffer. A transfer is armed by writing the control register with a start bit. From then on a pixel countdown tracks each data word and each read trigger. When the countdown reaches zero, the busy flag clears and a one-cycle frame-done pulse goes to an interrupt-status input.

Timing, line and sync registers are only stored and read back. They do not shape the external cycles.

Top module: `lcd_cmd_bridge`

## Requirements
- R1: After reset, these registers read as follows: control (offset 0x08) reads 2, both config registers (0x28, 0x2C) read 0x00310000, status (0x04) reads 0x1, pixel count (0x0C) reads 0. Also, `reg_ready` is 1 and no chip select is active.
- R2: The control register keeps only bits 3:0. Bit 0 is enable, bit 1 is bypass, bit 2 selects chip 0 and bit 3 selects chip 1.
- R3: A write to offset 0x14 (command) drives its low 16 bits with A0=0 to every selected chip. A write to 0x18 (parameter) does the same with A0=1. Each such cycle asserts select and write strobe for one clock in the cycle after the write is accepted.
- R4: A write to offset 0x1C (data) gives two A0=1 write cycles on every selected chip, in consecutive clocks, low half first. `reg_ready` is 0 during the first of them.
- R5: With no chip selected, command, parameter and data writes give no external cycle and no stall. A data write still decrements the pixel count.
- R6: A write to 0x20 runs a read cycle with A0=1, and a write to 0x24 runs one with A0=0. Chip 0 is read when both chips are selected. The returned word is latched into a receive buffer, which reads back in bits 15:0 at both 0x20 and 0x24.
- R7: Each write to 0x1C, 0x20 or 0x24 decrements the pixel count, which is loaded by writing 0x0C. When a decrement reaches zero during a transfer, busy clears and `frame_done` pulses for one clock.
- R8: A control write with bit 4 set starts a transfer (sets busy) only if all of the following hold: the written enable bit is 1, the written bypass bit is 0, `mode_en` is 1, the block is not busy, and the two config registers share no set bit in bits 3:2.
- R9: Status (0x04) returns 1 in bit 0 and the busy flag in bit 8, with all other bits 0.
- R10: The config registers keep the written value masked with 0x003F1FFF. The on/off-time registers (0x30, 0x38) use mask 0x3FFFFFFF, the cycle-time registers (0x34, 0x3C) use 0x0FFFFFFF, and the six data-cycle registers (0x40 to 0x54) use 0x0F1F0F1F.
- R11: The line register (0x10) keeps 11 bits, and the sync-width registers (0x58, 0x5C) keep 16 bits. The system-config register (0x00) keeps the value masked with 0x19. Writing it with bit 1 set returns every other register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write request, taken when reg_ready is 1 |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| reg_ready | output | 1 | Low while a second half or a read cycle is pending |
| mode_en | input | 1 | External permission to start a transfer |
| frame_done | output | 1 | One-clock pulse when the countdown ends a transfer |
| chip_cs | output | 2 | Per-chip select |
| chip_we | output | 2 | Per-chip write strobe |
| chip_rd | output | 2 | Per-chip read strobe |
| chip_a0 | output | 2 | Per-chip data/command line |
| chip_dout | output | 32 | Per-chip 16-bit write data, chip 0 in bits 15:0 |
| chip_din | input | 32 | Per-chip 16-bit read data, chip 0 in bits 15:0 |

## Verification
The bench aims at the following corner cases:
- **Half order of a data write.** A swapped order would put the high half first on the chips.
- **Ready during the pending second half.** A bridge that does not stall would accept a new word over a half still waiting to go out.
- **Read priority.** With both chips selected, a wrong priority returns chip 1's word.
- **Read A0 level.** Swapping the A0 levels of the two read triggers changes the low bit of the buffered word.
- **Empty selection.** The bench checks that with no chip selected the counter still moves and no cycle is issued.
- **Start gating.** Each start condition is denied once. A start that ignores bypass, enable, `mode_en` or the shared config bits shows busy where it must not.
- **End of countdown.** The bench expects busy to clear with exactly one `frame_done` pulse.
- **Soft reset.** A soft reset that misses a register leaves a masked value behind.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int HALF_W = 16;
    localparam int REG_DW = 2 * HALF_W;
    localparam int REG_AW = 8;
    localparam int N_CFG  = 2;
    localparam int N_DCYC = 6;

    // Register byte offsets
    localparam logic [REG_AW-1:0] A_SYSCFG  = 8'h00;
    localparam logic [REG_AW-1:0] A_SYSSTAT = 8'h04;
    localparam logic [REG_AW-1:0] A_CTRL    = 8'h08;
    localparam logic [REG_AW-1:0] A_PIXCNT  = 8'h0C;
    localparam logic [REG_AW-1:0] A_LINE    = 8'h10;
    localparam logic [REG_AW-1:0] A_CMD     = 8'h14;
    localparam logic [REG_AW-1:0] A_PARAM   = 8'h18;
    localparam logic [REG_AW-1:0] A_DATA    = 8'h1C;
    localparam logic [REG_AW-1:0] A_RDPAR   = 8'h20;
    localparam logic [REG_AW-1:0] A_RDSTAT  = 8'h24;
    localparam logic [REG_AW-1:0] A_CFG0    = 8'h28;
    localparam logic [REG_AW-1:0] A_CFG1    = 8'h2C;
    localparam logic [REG_AW-1:0] A_ONOFF0  = 8'h30;
    localparam logic [REG_AW-1:0] A_CYC0    = 8'h34;
    localparam logic [REG_AW-1:0] A_ONOFF1  = 8'h38;
    localparam logic [REG_AW-1:0] A_CYC1    = 8'h3C;
    localparam logic [REG_AW-1:0] A_DCYC0   = 8'h40;
    localparam logic [REG_AW-1:0] A_VSYNC   = 8'h58;
    localparam logic [REG_AW-1:0] A_HSYNC   = 8'h5C;

    localparam logic [REG_DW-1:0] M_SYS   = 32'h0000_0019;
    localparam logic [REG_DW-1:0] M_CFG   = 32'h003F_1FFF;
    localparam logic [REG_DW-1:0] M_ONOFF = 32'h3FFF_FFFF;
    localparam logic [REG_DW-1:0] M_CYC   = 32'h0FFF_FFFF;
    localparam logic [REG_DW-1:0] M_DCYC  = 32'h0F1F_0F1F;
    localparam logic [REG_DW-1:0] M_LINE  = 32'h0000_07FF;
    localparam logic [REG_DW-1:0] M_SYNC  = 32'h0000_FFFF;
    localparam logic [REG_DW-1:0] CFG_RST = 32'h0031_0000;
    localparam logic [REG_DW-1:0] CFG_LOCK = 32'h0000_000C;

    localparam int CB_EN    = 0;
    localparam int CB_BYP   = 1;
    localparam int CB_SEL   = 2;
    localparam int CB_START = 4;

    typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_PAIR, OP_READ} op_e;

    typedef struct packed {
        logic              we;
        logic              rd;
        logic              a0;
        logic [HALF_W-1:0] data;
    } bus_cyc_t;

    function automatic op_e decode_op(input logic [REG_AW-1:0] a);
        case (a)
            A_CMD, A_PARAM:    return OP_WRITE;
            A_DATA:            return OP_PAIR;
            A_RDPAR, A_RDSTAT: return OP_READ;
            default:           return OP_NONE;
        endcase
    endfunction

    // A0 level: low only for the command write and the status read
    function automatic logic op_a0(input logic [REG_AW-1:0] a);
        return !(a == A_CMD || a == A_RDSTAT);
    endfunction

    function automatic logic counts_pixel(input logic [REG_AW-1:0] a);
        return (a == A_DATA) || (a == A_RDPAR) || (a == A_RDSTAT);
    endfunction

endpackage

// File: rtl/lcd_cmd_cfg_regs.sv
module lcd_cmd_cfg_regs
    import lcd_cmd_pkg::*;
#(
    parameter int NCHIP  = 2,
    localparam int CTRL_W = CB_SEL + NCHIP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic              srst,
    output logic [CTRL_W-1:0] ctrl,
    output logic              cfg_lock,
    output logic [REG_DW-1:0] rdata
);
    logic [REG_DW-1:0] sys_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [REG_DW-1:0] line_q, vsync_q, hsync_q;
    logic [REG_DW-1:0] cfg_q   [N_CFG];
    logic [REG_DW-1:0] onoff_q [N_CFG];
    logic [REG_DW-1:0] cyc_q   [N_CFG];
    logic [REG_DW-1:0] dcyc_q  [N_DCYC];
    logic              clr;

    assign srst = wr_en && (addr == A_SYSCFG) && wdata[1];
    assign clr  = rst | srst;

    always_ff @(posedge clk) begin
        if (rst)
            sys_q <= '0;
        else if (wr_en && addr == A_SYSCFG)
            sys_q <= wdata & M_SYS;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            ctrl_q  <= CTRL_W'(2);
            line_q  <= '0;
            vsync_q <= '0;
            hsync_q <= '0;
            for (int s = 0; s < N_CFG; s++) begin
                cfg_q[s]   <= CFG_RST;
                onoff_q[s] <= '0;
                cyc_q[s]   <= '0;
            end
            for (int k = 0; k < N_DCYC; k++) dcyc_q[k] <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:   ctrl_q     <= wdata[CTRL_W-1:0];
                A_LINE:   line_q     <= wdata & M_LINE;
                A_VSYNC:  vsync_q    <= wdata & M_SYNC;
                A_HSYNC:  hsync_q    <= wdata & M_SYNC;
                A_CFG0:   cfg_q[0]   <= wdata & M_CFG;
                A_CFG1:   cfg_q[1]   <= wdata & M_CFG;
                A_ONOFF0: onoff_q[0] <= wdata & M_ONOFF;
                A_ONOFF1: onoff_q[1] <= wdata & M_ONOFF;
                A_CYC0:   cyc_q[0]   <= wdata & M_CYC;
                A_CYC1:   cyc_q[1]   <= wdata & M_CYC;
                default: ;
            endcase
            for (int k = 0; k < N_DCYC; k++)
                if (addr == A_DCYC0 + REG_AW'(4 * k)) dcyc_q[k] <= wdata & M_DCYC;
        end
    end

    always_comb begin
        case (addr)
            A_SYSCFG: rdata = sys_q;
            A_CTRL:   rdata = REG_DW'(ctrl_q);
            A_LINE:   rdata = line_q;
            A_VSYNC:  rdata = vsync_q;
            A_HSYNC:  rdata = hsync_q;
            A_CFG0:   rdata = cfg_q[0];
            A_CFG1:   rdata = cfg_q[1];
            A_ONOFF0: rdata = onoff_q[0];
            A_ONOFF1: rdata = onoff_q[1];
            A_CYC0:   rdata = cyc_q[0];
            A_CYC1:   rdata = cyc_q[1];
            default:  rdata = '0;
        endcase
        for (int k = 0; k < N_DCYC; k++)
            if (addr == A_DCYC0 + REG_AW'(4 * k)) rdata = dcyc_q[k];
    end

    assign ctrl     = ctrl_q;
    assign cfg_lock = |(cfg_q[0] & cfg_q[1] & CFG_LOCK);

endmodule

// File: rtl/lcd_cmd_bus_seq.sv
module lcd_cmd_bus_seq
    import lcd_cmd_pkg::*;
#(
    parameter int NCHIP = 2,
    localparam int IDX_W = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       addr,
    input  logic [REG_DW-1:0]       wdata,
    input  logic [NCHIP-1:0]        sel,
    input  logic [NCHIP*HALF_W-1:0] chip_din,
    output logic [NCHIP-1:0]        chip_cs,
    output logic [NCHIP-1:0]        chip_we,
    output logic [NCHIP-1:0]        chip_rd,
    output logic [NCHIP-1:0]        chip_a0,
    output logic [NCHIP*HALF_W-1:0] chip_dout,
    output logic                    ready,
    output logic [HALF_W-1:0]       rxbuf
);
    bus_cyc_t          cyc_q;
    logic [NCHIP-1:0]  cs_q, rd_oh;
    logic              pend_q;
    logic [HALF_W-1:0] hi_q, rx_q;
    logic [IDX_W-1:0]  rd_idx_q, rd_pick;
    op_e               op;

    assign op = wr_en ? decode_op(addr) : OP_NONE;

    // lowest selected chip wins a read
    always_comb begin
        rd_pick = '0;
        for (int i = NCHIP - 1; i >= 0; i--)
            if (sel[i]) rd_pick = IDX_W'(i);
        rd_oh = '0;
        rd_oh[rd_pick] = |sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q    <= '0;
            cs_q     <= '0;
            pend_q   <= 1'b0;
            hi_q     <= '0;
            rd_idx_q <= '0;
            rx_q     <= '0;
        end else begin
            if (cyc_q.rd) rx_q <= chip_din[rd_idx_q*HALF_W +: HALF_W];
            cyc_q  <= '0;
            cs_q   <= '0;
            pend_q <= 1'b0;
            if (pend_q) begin
                cyc_q.we   <= 1'b1;
                cyc_q.a0   <= 1'b1;
                cyc_q.data <= hi_q;
                cs_q       <= cs_q;
            end else begin
                case (op)
                    OP_WRITE, OP_PAIR: if (|sel) begin
                        cyc_q.we   <= 1'b1;
                        cyc_q.a0   <= op_a0(addr);
                        cyc_q.data <= wdata[HALF_W-1:0];
                        cs_q       <= sel;
                        pend_q     <= (op == OP_PAIR);
                        hi_q       <= wdata[REG_DW-1:HALF_W];
                    end
                    OP_READ: if (|sel) begin
                        cyc_q.rd <= 1'b1;
                        cyc_q.a0 <= op_a0(addr);
                        cs_q     <= rd_oh;
                        rd_idx_q <= rd_pick;
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar i = 0; i < NCHIP; i++) begin : g_chip
        assign chip_cs[i]                  = cs_q[i];
        assign chip_we[i]                  = cs_q[i] & cyc_q.we;
        assign chip_rd[i]                  = cs_q[i] & cyc_q.rd;
        assign chip_a0[i]                  = cyc_q.a0;
        assign chip_dout[i*HALF_W +: HALF_W] = cyc_q.data;
    end

    assign ready = !(pend_q | cyc_q.rd);
    assign rxbuf = rx_q;

    // R3
    we_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cyc_q.we && cyc_q.rd));
    // R6
    rd_single_chip_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_q.rd |-> ($countones(cs_q) == 1));
    // R4
    second_half_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> (cyc_q.we && cyc_q.a0 && !pend_q && ($past(cs_q) == cs_q)));

endmodule

// File: rtl/lcd_cmd_pixel_ctr.sv
module lcd_cmd_pixel_ctr
    import lcd_cmd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             start,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             frame_done
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                cnt_q <= load_val;
            end else if (step) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= busy_q;
                end
            end
            if (start && !busy_q) busy_q <= 1'b1;
        end
    end

    assign count      = cnt_q;
    assign busy       = busy_q;
    assign frame_done = done_q;

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy_q) && !busy_q));
    // R7
    busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && $past(busy_q) && !$past(rst)) |-> done_q);

endmodule

// File: rtl/lcd_cmd_bridge.sv
module lcd_cmd_bridge
    import lcd_cmd_pkg::*;
#(
    parameter int NCHIP = 2,
    parameter int PIX_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [REG_DW-1:0]       reg_wdata,
    output logic [REG_DW-1:0]       reg_rdata,
    output logic                    reg_ready,
    input  logic                    mode_en,
    output logic                    frame_done,
    output logic [NCHIP-1:0]        chip_cs,
    output logic [NCHIP-1:0]        chip_we,
    output logic [NCHIP-1:0]        chip_rd,
    output logic [NCHIP-1:0]        chip_a0,
    output logic [NCHIP*HALF_W-1:0] chip_dout,
    input  logic [NCHIP*HALF_W-1:0] chip_din
);
    localparam int CTRL_W = CB_SEL + NCHIP;

    logic              wr_acc, srst, clr, cfg_lock, busy, start, step, load;
    logic [CTRL_W-1:0] ctrl;
    logic [REG_DW-1:0] cfg_rdata;
    logic [PIX_W-1:0]  pix_count;
    logic [HALF_W-1:0] rxbuf;

    assign wr_acc = reg_wr && reg_ready;
    assign clr    = rst | srst;

    assign start = wr_acc && (reg_addr == A_CTRL) && reg_wdata[CB_START]
                && reg_wdata[CB_EN] && !reg_wdata[CB_BYP] && mode_en && !cfg_lock;
    assign step  = wr_acc && counts_pixel(reg_addr);
    assign load  = wr_acc && (reg_addr == A_PIXCNT);

    lcd_cmd_cfg_regs #(.NCHIP(NCHIP)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_acc), .addr(reg_addr), .wdata(reg_wdata),
        .srst(srst), .ctrl(ctrl), .cfg_lock(cfg_lock), .rdata(cfg_rdata)
    );

    lcd_cmd_bus_seq #(.NCHIP(NCHIP)) u_seq (
        .clk(clk), .rst(clr), .wr_en(wr_acc), .addr(reg_addr), .wdata(reg_wdata),
        .sel(ctrl[CB_SEL +: NCHIP]), .chip_din(chip_din),
        .chip_cs(chip_cs), .chip_we(chip_we), .chip_rd(chip_rd), .chip_a0(chip_a0),
        .chip_dout(chip_dout), .ready(reg_ready), .rxbuf(rxbuf)
    );

    lcd_cmd_pixel_ctr #(.CNT_W(PIX_W)) u_pix (
        .clk(clk), .rst(clr), .load(load), .load_val(PIX_W'(reg_wdata)),
        .step(step), .start(start), .count(pix_count), .busy(busy),
        .frame_done(frame_done)
    );

    always_comb begin
        case (reg_addr)
            A_SYSSTAT:         reg_rdata = {23'd0, busy, 7'd0, 1'b1};
            A_PIXCNT:          reg_rdata = REG_DW'(pix_count);
            A_RDPAR, A_RDSTAT: reg_rdata = REG_DW'(rxbuf);
            default:           reg_rdata = cfg_rdata;
        endcase
    end

endmodule

// File: tb/lcd_cmd_bridge_tb.sv
module lcd_cmd_bridge_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready, mode_en = 1'b0, frame_done;
    logic [1:0]  chip_cs, chip_we, chip_rd, chip_a0;
    logic [31:0] chip_dout, chip_din;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic ready_after;

    always #5 clk = ~clk;

    // chip i returns a fixed tag byte, with A0 in bit 0
    assign chip_din = {8'hB1, 7'd0, chip_a0[1], 8'hA0, 7'd0, chip_a0[0]};

    lcd_cmd_bridge u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .mode_en(mode_en), .frame_done(frame_done), .chip_cs(chip_cs),
        .chip_we(chip_we), .chip_rd(chip_rd), .chip_a0(chip_a0),
        .chip_dout(chip_dout), .chip_din(chip_din)
    );

    // external write-cycle log, {a0, data}, per chip
    logic [16:0] log0 [64];
    logic [16:0] log1 [64];
    int n0 = 0, n1 = 0, n_done = 0;
    always @(negedge clk) if (!rst) begin
        if (chip_we[0]) begin log0[n0 % 64] <= {chip_a0[0], chip_dout[15:0]};  n0 <= n0 + 1; end
        if (chip_we[1]) begin log1[n1 % 64] <= {chip_a0[1], chip_dout[31:16]}; n1 <= n1 + 1; end
        if (frame_done) n_done <= n_done + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!reg_ready) @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        ready_after = reg_ready;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // {addr, write value, expected read-back}
    localparam logic [71:0] VEC [12] = '{
        {8'h28, 32'hFFFF_FFFF, 32'h003F_1FFF},
        {8'h2C, 32'h1234_5678, 32'h0034_1678},
        {8'h30, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
        {8'h38, 32'hC000_0001, 32'h0000_0001},
        {8'h34, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
        {8'h3C, 32'hF000_0010, 32'h0000_0010},
        {8'h40, 32'hFFFF_FFFF, 32'h0F1F_0F1F},
        {8'h54, 32'h1234_5678, 32'h0214_0618},
        {8'h10, 32'hFFFF_FFFF, 32'h0000_07FF},
        {8'h58, 32'hFFFF_FFFF, 32'h0000_FFFF},
        {8'h5C, 32'h0001_ABCD, 32'h0000_ABCD},
        {8'h0C, 32'h0000_0007, 32'h0000_0007}
    };

    initial begin
        logic [31:0] v;
        int b0, b1, d0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h08, v); chk("R1", "ctrl reset", v, 32'h2);
        rd(8'h28, v); chk("R1", "cfg0 reset", v, 32'h0031_0000);
        rd(8'h2C, v); chk("R1", "cfg1 reset", v, 32'h0031_0000);
        rd(8'h04, v); chk("R9", "status reset", v, 32'h1);
        rd(8'h0C, v); chk("R1", "pixcount reset", v, 32'h0);
        chk("R1", "ready reset", {31'd0, reg_ready}, 32'h1);
        chk("R1", "no select", {30'd0, chip_cs}, 32'h0);

        // R10 R11 masking table
        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk("R10", $sformatf("mask @%h", VEC[i][71:64]), v, VEC[i][31:0]);
        end

        // R11 soft reset
        wr(8'h00, 32'h0000_001B);
        rd(8'h00, v); chk("R11", "sysconfig mask", v, 32'h19);
        rd(8'h08, v); chk("R11", "ctrl after soft reset", v, 32'h2);
        rd(8'h28, v); chk("R11", "cfg0 after soft reset", v, 32'h0031_0000);
        rd(8'h10, v); chk("R11", "line after soft reset", v, 32'h0);
        rd(8'h0C, v); chk("R11", "pixcount after soft reset", v, 32'h0);

        // R2 control keeps 4 bits; R3 command to chip 0 only
        wr(8'h08, 32'hFFFF_FFF5);
        rd(8'h08, v); chk("R2", "ctrl width", v, 32'h5);
        b0 = n0; b1 = n1;
        wr(8'h14, 32'h1234_ABCD);
        repeat (3) @(negedge clk);
        chk("R3", "cmd count chip0", n0 - b0, 1);
        chk("R3", "cmd count chip1", n1 - b1, 0);
        chk("R3", "cmd word", {15'd0, log0[b0 % 64]}, {15'd0, 1'b0, 16'hABCD});

        // R3 parameter to both chips
        wr(8'h08, 32'hD);
        b0 = n0; b1 = n1;
        wr(8'h18, 32'h0000_5A5A);
        repeat (3) @(negedge clk);
        chk("R3", "param chip0", {15'd0, log0[b0 % 64]}, {15'd0, 1'b1, 16'h5A5A});
        chk("R3", "param chip1", {15'd0, log1[b1 % 64]}, {15'd0, 1'b1, 16'h5A5A});

        // R4 data pair, low half first, stall on second half
        b0 = n0; b1 = n1;
        wr(8'h1C, 32'hDEAD_BEEF);
        chk("R4", "ready low during first half", {31'd0, ready_after}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R4", "data count chip0", n0 - b0, 2);
        chk("R4", "data low chip0", {15'd0, log0[b0 % 64]}, {15'd0, 1'b1, 16'hBEEF});
        chk("R4", "data high chip0", {15'd0, log0[(b0 + 1) % 64]}, {15'd0, 1'b1, 16'hDEAD});
        chk("R4", "data high chip1", {15'd0, log1[(b1 + 1) % 64]}, {15'd0, 1'b1, 16'hDEAD});

        // R5 no chip selected
        wr(8'h08, 32'h1);
        wr(8'h0C, 32'h5);
        b0 = n0; b1 = n1;
        wr(8'h1C, 32'h1111_2222);
        chk("R5", "no stall", {31'd0, ready_after}, 32'h1);
        wr(8'h14, 32'h3333);
        repeat (3) @(negedge clk);
        chk("R5", "no cycles", (n0 - b0) + (n1 - b1), 0);
        rd(8'h0C, v); chk("R5", "count still moves", v, 32'h4);

        // R6 reads: chip 0 priority, A0 levels, shared buffer
        wr(8'h08, 32'hD);
        wr(8'h20, 32'h0);
        repeat (2) @(negedge clk);
        rd(8'h20, v); chk("R6", "read param chip0", v, 32'h0000_A001);
        rd(8'h24, v); chk("R6", "buffer via status offset", v, 32'h0000_A001);
        wr(8'h08, 32'h9);
        wr(8'h24, 32'h0);
        repeat (2) @(negedge clk);
        rd(8'h20, v); chk("R6", "read status chip1", v, 32'h0000_B100);
        rd(8'h0C, v); chk("R7", "read triggers count", v, 32'h2);

        // R7 R8 R9 transfer start and countdown
        mode_en = 1'b1;
        d0 = n_done;
        wr(8'h0C, 32'h2);
        wr(8'h08, 32'h1D);
        rd(8'h04, v); chk("R9", "busy in status", v, 32'h101);
        wr(8'h1C, 32'h0);
        rd(8'h04, v); chk("R7", "still busy at 1", v, 32'h101);
        wr(8'h1C, 32'h0);
        repeat (3) @(negedge clk);
        rd(8'h04, v); chk("R7", "busy cleared at 0", v, 32'h1);
        chk("R7", "one frame-done pulse", n_done - d0, 1);

        // R8 denied starts
        mode_en = 1'b0;
        wr(8'h08, 32'h1D);
        rd(8'h04, v); chk("R8", "mode_en low", v, 32'h1);
        mode_en = 1'b1;
        wr(8'h08, 32'h1F);
        rd(8'h04, v); chk("R8", "bypass set", v, 32'h1);
        wr(8'h08, 32'h1C);
        rd(8'h04, v); chk("R8", "enable clear", v, 32'h1);
        wr(8'h28, 32'h4);
        wr(8'h2C, 32'h4);
        wr(8'h08, 32'h1D);
        rd(8'h04, v); chk("R8", "config lock", v, 32'h1);
        wr(8'h2C, 32'h8);
        wr(8'h08, 32'h1D);
        rd(8'h04, v); chk("R8", "no shared lock bit starts", v, 32'h101);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule